// File: doc/BRIEF.md
# Partitioned Register Pool with Core Count

This block holds a pool of 32 general registers, each 32 bits wide, kept in four banks of eight. The register pool is shared among one, two or four logical cores. Before an application is started, a configuration word is loaded over a debug port. It gives the number of registers each core needs, and the block derives from it how many logical cores fit in the pool (32 divided by that number). While the application runs, a pipeline reaches its registers through two combinational read ports and one write port. Each access is addressed by a core number and a register index inside that core's window.

The debug port takes a 4-bit operation code and a 16-bit address. Code 0x4 reads and code 0x5 writes. Addresses 1024 to 1055 map one-to-one onto the 32 physical registers, and address 1056 holds the configuration word. The block drives the current core count, a configuration error flag and one write-enable strobe per bank.

Top module: `regpool_top`

## Requirements
- R1: After reset, core_count is 1, the register requirement is 32, cfg_err is 0, dbg_rvalid is 0 and every register reads as zero.
- R2: Physical register p lives in bank p[4:3]. bank_we[b] is high in exactly the cycles in which some write (pipeline or debug) lands in bank b.
- R3: With dbg_valid high, code 0x5 at address 1024+n writes dbg_wdata into physical register n. Code 0x4 at address 1024+n puts register n on dbg_rdata with dbg_rvalid high in the next cycle. Any other code changes nothing. A read outside 1024..1056 returns 0.
- R4: A debug write of v to address 1056, with v equal to 8, 16 or 32 and run low, makes the requirement v and core_count 32/v from the next cycle.
- R5: A configuration write of any other value leaves the requirement and core_count unchanged and sets cfg_err. The next accepted configuration write clears cfg_err.
- R6: A configuration write made while run is high is rejected in the same way as in R5.
- R7: A pipeline access by core c to index i reaches physical register (c mod core_count) * req + (i mod req), where req is the register requirement.
- R8: When the pipeline write and a debug write hit the same physical register in the same cycle, the register keeps the debug data.
- R9: A pipeline read of the register being written in the same cycle returns the new data, with debug data taking precedence as in R8.
- R10: A debug read of address 1056 returns the requirement in bits 7:0 and core_count in bits 15:8, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Application running; blocks configuration writes |
| rd0_core | input | 2 | Core number for read port 0 |
| rd0_idx | input | 5 | Register index for read port 0 |
| rd0_data | output | 32 | Read data, port 0 (combinational) |
| rd1_core | input | 2 | Core number for read port 1 |
| rd1_idx | input | 5 | Register index for read port 1 |
| rd1_data | output | 32 | Read data, port 1 (combinational) |
| wr_en | input | 1 | Pipeline write enable |
| wr_core | input | 2 | Core number for the pipeline write |
| wr_idx | input | 5 | Register index for the pipeline write |
| wr_data | input | 32 | Pipeline write data |
| dbg_valid | input | 1 | Debug command strobe |
| dbg_op | input | 4 | Debug operation code (0x4 read, 0x5 write) |
| dbg_addr | input | 16 | Debug address |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data, registered |
| dbg_rvalid | output | 1 | dbg_rdata is valid this cycle |
| core_count | output | 6 | Number of logical cores sharing the pool |
| cfg_err | output | 1 | Last configuration write was rejected |
| bank_we | output | 4 | Per-bank write strobe |

## Verification
A wrong configuration state appears in the cycle after the bad write, on core_count, cfg_err and the word read from 1056. A bad address mapping stays hidden until data written through one path is read back through the other. For that reason the pipeline writes in the tests are read back over debug addresses, and debug writes are read back on the pipeline ports. A wrong collision priority or missing forwarding shows within one cycle, either on the combinational read port before the clock edge or on the debug read issued right after it.

// File: rtl/regpool_pkg.sv
package regpool_pkg;
    localparam logic [3:0] DBG_OP_READ  = 4'h4;
    localparam logic [3:0] DBG_OP_WRITE = 4'h5;
endpackage

// File: rtl/regpool_cfg.sv
module regpool_cfg #(
    parameter int NUM_REGS = 32,
    parameter int MIN_REQ  = 8,
    parameter int VAL_W    = 6,
    parameter int IN_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr_en,
    input  logic [IN_W-1:0]  wr_val,
    output logic [VAL_W-1:0] req_o,
    output logic [VAL_W-1:0] cc_o,
    output logic             err_o
);
    localparam int NUM_LOG = $clog2(NUM_REGS);
    localparam int MIN_LOG = $clog2(MIN_REQ);

    typedef struct packed {
        logic [VAL_W-1:0] req;
        logic [VAL_W-1:0] cc;
        logic             err;
    } cfg_t;

    cfg_t             s_d, s_q;
    logic             legal;
    logic [VAL_W-1:0] cc_new;

    always_comb begin
        s_d    = s_q;
        legal  = 1'b0;
        cc_new = s_q.cc;
        for (int k = MIN_LOG; k <= NUM_LOG; k++) begin
            if (wr_val == IN_W'(1 << k)) begin
                legal  = 1'b1;
                cc_new = VAL_W'(NUM_REGS / (1 << k));
            end
        end
        if (wr_en) begin
            if (legal && !run) begin
                s_d.req = wr_val[VAL_W-1:0];
                s_d.cc  = cc_new;
                s_d.err = 1'b0;
            end else begin
                s_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{req: VAL_W'(NUM_REGS), cc: VAL_W'(1), err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_o = s_q.req;
    assign cc_o  = s_q.cc;
    assign err_o = s_q.err;

    assert_cc_times_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cc_o) * 32'(req_o)) == NUM_REGS);

    assert_reject_keeps_cc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !legal) |=> ($stable(cc_o) && $stable(req_o) && err_o));

    assert_run_blocks_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && run) |=> ($stable(req_o) && err_o));

    assert_accept_clears_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && legal && !run) |=> !err_o);
endmodule

// File: rtl/regpool_bank.sv
module regpool_bank #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pw_en,
    input  logic [IDX_W-1:0]  pw_idx,
    input  logic [DATA_W-1:0] pw_data,
    input  logic              dw_en,
    input  logic [IDX_W-1:0]  dw_idx,
    input  logic [DATA_W-1:0] dw_data,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic [IDX_W-1:0]  rc_idx,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data,
    output logic [DATA_W-1:0] rc_data
);
    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (pw_en) mem_d[pw_idx] = pw_data;
        if (dw_en) mem_d[dw_idx] = dw_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign ra_data = mem_q[ra_idx];
    assign rb_data = mem_q[rb_idx];
    assign rc_data = mem_q[rc_idx];

    assert_debug_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_en && dw_en && pw_idx == dw_idx) |=> (mem_q[$past(dw_idx)] == $past(dw_data)));
endmodule

// File: rtl/regpool_top.sv
module regpool_top #(
    parameter int NUM_REGS  = 32,
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 4,
    parameter int DBG_AW    = 16,
    parameter int DBG_BASE  = 1024,
    parameter int MIN_REQ   = 8,
    localparam int ADDR_W   = $clog2(NUM_REGS),
    localparam int CORE_W   = $clog2(NUM_REGS / MIN_REQ),
    localparam int VAL_W    = $clog2(NUM_REGS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CORE_W-1:0] rd0_core,
    input  logic [ADDR_W-1:0] rd0_idx,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [CORE_W-1:0] rd1_core,
    input  logic [ADDR_W-1:0] rd1_idx,
    output logic [DATA_W-1:0] rd1_data,
    input  logic              wr_en,
    input  logic [CORE_W-1:0] wr_core,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              dbg_valid,
    input  logic [3:0]        dbg_op,
    input  logic [DBG_AW-1:0] dbg_addr,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic [DATA_W-1:0] dbg_rdata,
    output logic              dbg_rvalid,
    output logic [VAL_W-1:0]  core_count,
    output logic              cfg_err,
    output logic [NUM_BANKS-1:0] bank_we
);
    import regpool_pkg::*;

    localparam int BANK_REGS = NUM_REGS / NUM_BANKS;
    localparam int LOC_W     = $clog2(BANK_REGS);
    localparam int BANK_W    = ADDR_W - LOC_W;
    localparam int CFG_ADDR  = DBG_BASE + NUM_REGS;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } dbg_t;

    dbg_t dbg_d, dbg_q;

    logic [VAL_W-1:0]  req;
    logic              is_rd, is_wr, in_win, at_cfg;
    logic [ADDR_W-1:0] dphys, pphys, rphys0, rphys1;
    logic              dw_en;
    logic [DATA_W-1:0] cfg_word;

    logic [NUM_BANKS-1:0][DATA_W-1:0] b_ra, b_rb, b_rc;
    logic [DATA_W-1:0] raw0, raw1, rawd;

    function automatic logic [ADDR_W-1:0] to_phys(
        input logic [CORE_W-1:0] c,
        input logic [ADDR_W-1:0] i,
        input logic [VAL_W-1:0]  rq,
        input logic [VAL_W-1:0]  cn
    );
        logic [CORE_W-1:0] ce;
        logic [ADDR_W-1:0] ie;
        int unsigned       sum;
        ce  = c & CORE_W'(cn - 1'b1);
        ie  = i & ADDR_W'(rq - 1'b1);
        sum = 32'(ce) * 32'(rq) + 32'(ie);
        return ADDR_W'(sum);
    endfunction

    function automatic logic [DATA_W-1:0] forward(
        input logic [ADDR_W-1:0] p,
        input logic [DATA_W-1:0] raw,
        input logic              d_en,
        input logic [ADDR_W-1:0] d_p,
        input logic [DATA_W-1:0] d_v,
        input logic              p_en,
        input logic [ADDR_W-1:0] p_p,
        input logic [DATA_W-1:0] p_v
    );
        if (d_en && d_p == p)      return d_v;
        else if (p_en && p_p == p) return p_v;
        else                       return raw;
    endfunction

    // command decode
    always_comb begin
        is_rd  = dbg_valid && (dbg_op == DBG_OP_READ);
        is_wr  = dbg_valid && (dbg_op == DBG_OP_WRITE);
        in_win = (32'(dbg_addr) >= DBG_BASE) && (32'(dbg_addr) < DBG_BASE + NUM_REGS);
        at_cfg = (32'(dbg_addr) == CFG_ADDR);
        dphys  = ADDR_W'(32'(dbg_addr) - DBG_BASE);
        dw_en  = is_wr && in_win;
        pphys  = to_phys(wr_core, wr_idx, req, core_count);
        rphys0 = to_phys(rd0_core, rd0_idx, req, core_count);
        rphys1 = to_phys(rd1_core, rd1_idx, req, core_count);
    end

    regpool_cfg #(
        .NUM_REGS (NUM_REGS),
        .MIN_REQ  (MIN_REQ),
        .VAL_W    (VAL_W),
        .IN_W     (DATA_W)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .wr_en  (is_wr && at_cfg),
        .wr_val (dbg_wdata),
        .req_o  (req),
        .cc_o   (core_count),
        .err_o  (cfg_err)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic pw_hit, dw_hit;
        assign pw_hit = wr_en && (pphys[ADDR_W-1 -: BANK_W] == BANK_W'(b));
        assign dw_hit = dw_en && (dphys[ADDR_W-1 -: BANK_W] == BANK_W'(b));
        assign bank_we[b] = pw_hit | dw_hit;

        regpool_bank #(
            .DEPTH  (BANK_REGS),
            .DATA_W (DATA_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .pw_en   (pw_hit),
            .pw_idx  (pphys[LOC_W-1:0]),
            .pw_data (wr_data),
            .dw_en   (dw_hit),
            .dw_idx  (dphys[LOC_W-1:0]),
            .dw_data (dbg_wdata),
            .ra_idx  (rphys0[LOC_W-1:0]),
            .rb_idx  (rphys1[LOC_W-1:0]),
            .rc_idx  (dphys[LOC_W-1:0]),
            .ra_data (b_ra[b]),
            .rb_data (b_rb[b]),
            .rc_data (b_rc[b])
        );
    end

    always_comb begin
        raw0 = b_ra[rphys0[ADDR_W-1 -: BANK_W]];
        raw1 = b_rb[rphys1[ADDR_W-1 -: BANK_W]];
        rawd = b_rc[dphys[ADDR_W-1 -: BANK_W]];
        rd0_data = forward(rphys0, raw0, dw_en, dphys, dbg_wdata, wr_en, pphys, wr_data);
        rd1_data = forward(rphys1, raw1, dw_en, dphys, dbg_wdata, wr_en, pphys, wr_data);
        cfg_word = '0;
        cfg_word[VAL_W-1:0]  = req;
        cfg_word[8 +: VAL_W] = core_count;
    end

    always_comb begin
        dbg_d        = dbg_q;
        dbg_d.rvalid = is_rd;
        if (is_rd) begin
            if (in_win)
                dbg_d.rdata = forward(dphys, rawd, 1'b0, dphys, dbg_wdata, wr_en, pphys, wr_data);
            else if (at_cfg)
                dbg_d.rdata = cfg_word;
            else
                dbg_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dbg_q <= '{rdata: '0, rvalid: 1'b0};
        else        dbg_q <= dbg_d;
    end

    assign dbg_rdata  = dbg_q.rdata;
    assign dbg_rvalid = dbg_q.rvalid;

    assert_rvalid_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> dbg_rvalid);

    assert_no_spurious_rvalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> !dbg_rvalid);

    assert_bank_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bank_we) <= 2);

    assert_no_write_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !dw_en) |-> (bank_we == '0));
endmodule

// File: tb/regpool_top_test.sv
module regpool_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [1:0]  rd0_core = '0, rd1_core = '0, wr_core = '0;
    logic [4:0]  rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
    logic [31:0] rd0_data, rd1_data, wr_data = '0;
    logic        wr_en = 1'b0;
    logic        dbg_valid = 1'b0;
    logic [3:0]  dbg_op = '0;
    logic [15:0] dbg_addr = '0;
    logic [31:0] dbg_wdata = '0, dbg_rdata;
    logic        dbg_rvalid;
    logic [5:0]  core_count;
    logic        cfg_err;
    logic [3:0]  bank_we;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    regpool_top uut (
        .clk(clk), .rst_n(rst_n), .run(run),
        .rd0_core(rd0_core), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
        .rd1_core(rd1_core), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_core(wr_core), .wr_idx(wr_idx), .wr_data(wr_data),
        .dbg_valid(dbg_valid), .dbg_op(dbg_op), .dbg_addr(dbg_addr),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .dbg_rvalid(dbg_rvalid),
        .core_count(core_count), .cfg_err(cfg_err), .bank_we(bank_we)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic dbg_cmd(input logic [3:0] op, input int addr, input logic [31:0] d);
        @(negedge clk);
        dbg_valid = 1'b1; dbg_op = op; dbg_addr = 16'(addr); dbg_wdata = d;
        @(negedge clk);
        dbg_valid = 1'b0; dbg_op = '0;
    endtask

    task automatic dbg_read_check(input string tag, input int addr, input logic [31:0] exp);
        dbg_cmd(4'h4, addr, '0);
        #1;
        check({tag, " rvalid"}, 32'(dbg_rvalid), 32'd1);
        check(tag, dbg_rdata, exp);
    endtask

    task automatic pipe_write(input logic [1:0] c, input logic [4:0] i, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_core = c; wr_idx = i; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R1 core_count", 32'(core_count), 32'd1);
        check("R1 cfg_err", 32'(cfg_err), 32'd0);
        check("R1 dbg_rvalid", 32'(dbg_rvalid), 32'd0);
        check("R1 rd0_data", rd0_data, 32'd0);
        dbg_read_check("R1 reg31 zero", 1055, 32'd0);
        dbg_read_check("R10 cfg word", 1056, 32'h0000_0120);
    endtask

    task automatic t_debug();
        dbg_cmd(4'h5, 1029, 32'hA5A5_0005);
        dbg_read_check("R3 readback 1029", 1029, 32'hA5A5_0005);
        @(negedge clk);
        dbg_valid = 1'b1; dbg_op = 4'h5; dbg_addr = 16'd1044; dbg_wdata = 32'h0000_0014;
        #1;
        check("R2 bank_we reg20", 32'(bank_we), 32'h4);
        @(negedge clk);
        dbg_valid = 1'b0;
        #1;
        check("R2 bank_we idle", 32'(bank_we), 32'h0);
        rd0_core = 2'd0; rd0_idx = 5'd20;
        #1;
        check("R3 pipe sees debug write", rd0_data, 32'h0000_0014);
        dbg_cmd(4'h6, 1030, 32'hDEAD_BEEF);
        dbg_read_check("R3 bad op ignored", 1030, 32'd0);
        dbg_cmd(4'h5, 1100, 32'h1234_5678);
        dbg_read_check("R3 outside window", 1100, 32'd0);
        check("R3 cfg untouched", 32'(core_count), 32'd1);
    endtask

    task automatic t_cfg();
        dbg_cmd(4'h5, 1056, 32'd8);
        #1;
        check("R4 cc for 8", 32'(core_count), 32'd4);
        check("R4 err clear", 32'(cfg_err), 32'd0);
        dbg_read_check("R10 cfg word 8", 1056, 32'h0000_0408);
        dbg_cmd(4'h5, 1056, 32'd12);
        #1;
        check("R5 cc unchanged", 32'(core_count), 32'd4);
        check("R5 err set", 32'(cfg_err), 32'd1);
        dbg_cmd(4'h5, 1056, 32'd40);
        #1;
        check("R5 cc unchanged 40", 32'(core_count), 32'd4);
        dbg_cmd(4'h5, 1056, 32'd16);
        #1;
        check("R4 cc for 16", 32'(core_count), 32'd2);
        check("R5 err cleared", 32'(cfg_err), 32'd0);
        run = 1'b1;
        dbg_cmd(4'h5, 1056, 32'd32);
        #1;
        check("R6 cc held while run", 32'(core_count), 32'd2);
        check("R6 err while run", 32'(cfg_err), 32'd1);
        run = 1'b0;
        dbg_read_check("R6 req held", 1056, 32'h0000_0210);
    endtask

    task automatic t_map();
        dbg_cmd(4'h5, 1056, 32'd8);
        pipe_write(2'd2, 5'd1, 32'h0000_C201);
        dbg_read_check("R7 core2 idx1 -> 17", 1041, 32'h0000_C201);
        pipe_write(2'd1, 5'd9, 32'h0000_C109);
        dbg_read_check("R7 core1 idx9 -> 9", 1033, 32'h0000_C109);
        dbg_cmd(4'h5, 1056, 32'd16);
        rd1_core = 2'd3; rd1_idx = 5'd1;
        #1;
        check("R7 core3 wraps to core1", rd1_data, 32'h0000_C201);
        dbg_cmd(4'h5, 1056, 32'd32);
        rd1_core = 2'd3; rd1_idx = 5'd9;
        #1;
        check("R7 single core", rd1_data, 32'h0000_C109);
    endtask

    task automatic t_collide();
        @(negedge clk);
        wr_en = 1'b1; wr_core = 2'd0; wr_idx = 5'd3; wr_data = 32'h1111_1111;
        dbg_valid = 1'b1; dbg_op = 4'h5; dbg_addr = 16'd1027; dbg_wdata = 32'h2222_2222;
        rd0_core = 2'd0; rd0_idx = 5'd3;
        #1;
        check("R9 bypass prefers debug", rd0_data, 32'h2222_2222);
        check("R2 bank_we collision", 32'(bank_we), 32'h1);
        @(negedge clk);
        wr_en = 1'b0; dbg_valid = 1'b0;
        #1;
        check("R8 debug wins", rd0_data, 32'h2222_2222);
    endtask

    task automatic t_bypass();
        @(negedge clk);
        wr_en = 1'b1; wr_core = 2'd0; wr_idx = 5'd7; wr_data = 32'h7777_0007;
        rd0_core = 2'd0; rd0_idx = 5'd7;
        rd1_core = 2'd0; rd1_idx = 5'd8;
        #1;
        check("R9 same-cycle bypass", rd0_data, 32'h7777_0007);
        check("R9 other reg unaffected", rd1_data, 32'd0);
        check("R2 bank_we bank0", 32'(bank_we), 32'h1);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R9 stored after edge", rd0_data, 32'h7777_0007);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_debug();
        t_cfg();
        t_map();
        t_collide();
        t_bypass();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule